// File: doc/BRIEF.md
# Enabled-Channel Sample Packer

This block gathers samples from a multichannel source, such as a converter front end, and turns them into one dense output stream for a single sink, such as a DMA write FIFO. Each source channel has its own enable bit and data bus. All channels share one write strobe. When the strobe is high, only the enabled channels contribute their samples. Disabled channels leave no gap in the output.

Accepted samples are placed back to back into an internal slot buffer. The order is sample-interleaved: sample 0 of each enabled channel, lowest channel first, then sample 1 of each enabled channel, and so on. When a full output word has been assembled, the block writes it to the sink for one cycle. Samples that do not fit in that word stay at the bottom of the buffer and start the next word.

The source sets the pace and there is no backpressure. The sink's overflow flag is passed straight through to the source. A sync flag travels with every word whose first slot opens a new sample group. Changing the channel selection discards any partly built word.

Top module: `cpk_sample_packer`

## Requirements
- R1: While reset is high and in the cycle after reset, `snk_wr_o` and `snk_sync_o` are low. Reset empties the slot buffer.
- R2: On a strobe, only enabled channels are taken. Their samples fill consecutive slots with no gaps, in ascending channel order. Slot i of `snk_data_o` is bits [i*SW +: SW], so slot 0 is at the LSB end.
- R3: With more than one sample per channel, sample k of channel c sits in bits [(c*SPC+k)*SW +: SW] of `ch_data_i`. The output is interleaved: every enabled channel's sample k comes before any channel's sample k+1.
- R4: `snk_wr_o` pulses high for one cycle, in the cycle after the strobe that fills the last slot. `snk_data_o` carries the full word in that same cycle.
- R5: Samples left over beyond a full word are kept, in order, and fill the lowest slots of the next word.
- R6: `snk_sync_o` is high with a write exactly when that word's slot 0 holds sample 0 of the lowest enabled channel. When all channels are enabled, every strobe produces a synced word.
- R7: A change in `ch_en_i` from one cycle to the next discards the partly filled buffer without writing it. A strobe in that same cycle is packed into the emptied buffer under the new selection.
- R8: When `ch_en_i` is all zero, strobes are ignored: no write follows, and no sample is kept for later words.
- R9: Without a strobe there is no write, whatever the enables are.
- R10: `src_ovf_o` follows `snk_ovf_i` combinationally, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ch_wr_i | input | 1 | Shared write strobe from the source |
| ch_en_i | input | NCH | Per-channel enable |
| ch_data_i | input | NCH*SPC*SW | Channel data. Channel c occupies bits [c*SPC*SW +: SPC*SW] |
| src_ovf_o | output | 1 | Overflow flag returned to the source |
| snk_wr_o | output | 1 | Write enable to the sink |
| snk_data_o | output | NCH*SPC*SW | Packed output word |
| snk_sync_o | output | 1 | Word starts on a sample-group boundary |
| snk_ovf_i | input | 1 | Overflow flag from the sink |

## Verification
A fill count that drifts would show up at the ports as samples moved by one or more slots. It would also change how often writes occur, visible at the latest on the next write, which comes within NCH*SPC strobes. A group-start flag in the wrong state would put `snk_sync_o` on the wrong word at that same next write. A stale copy of the enable vector would leave the buffer uncleared after a selection change, so the first word after the change would carry old samples. The directed sequences use channel subsets whose group size does not divide the word width, so carried-over samples cross word boundaries and each of these faults shows up in the next two or three words.

// File: rtl/cpk_pkg.sv
package cpk_pkg;

    typedef struct packed {
        logic wr;
        logic sync;
    } cpk_emit_t;

    // samples taken from one strobe
    function automatic int cpk_group_size(int n_enabled, int per_channel);
        return n_enabled * per_channel;
    endfunction

endpackage

// File: rtl/cpk_rank.sv
// Prefix-sum rank of each channel among the enabled ones, plus the total.
module cpk_rank #(
    parameter int NCH = 4,
    parameter int CW  = 3
) (
    input  logic [NCH-1:0]         en_i,
    output logic [NCH-1:0][CW-1:0] rank_o,
    output logic [CW-1:0]          count_o
);
    always_comb begin
        logic [CW-1:0] acc;
        acc = '0;
        for (int c = 0; c < NCH; c++) begin
            rank_o[c] = acc;
            acc = acc + CW'(en_i[c]);
        end
        count_o = acc;
    end
endmodule

// File: rtl/cpk_place.sv
// Scatters enabled samples into a double-width slot window starting at the fill count.
module cpk_place #(
    parameter int NCH = 4,
    parameter int SPC = 1,
    parameter int SW  = 16,
    parameter int CW  = 3,
    parameter int FW  = 3
) (
    input  logic [NCH-1:0]            en_i,
    input  logic [NCH-1:0][CW-1:0]    rank_i,
    input  logic [CW-1:0]             count_i,
    input  logic [FW-1:0]             fill_i,
    input  logic [NCH*SPC*SW-1:0]     data_i,
    output logic [2*NCH*SPC-1:0]      vld_o,
    output logic [2*NCH*SPC-1:0][SW-1:0] dat_o
);
    localparam int NSLOT = NCH * SPC;

    always_comb begin
        vld_o = '0;
        dat_o = '0;
        for (int p = 0; p < 2 * NSLOT; p++) begin
            for (int c = 0; c < NCH; c++) begin
                for (int s = 0; s < SPC; s++) begin
                    if (en_i[c] &&
                        (int'(fill_i) + s * int'(count_i) + int'(rank_i[c]) == p)) begin
                        vld_o[p] = 1'b1;
                        dat_o[p] = data_i[(c*SPC+s)*SW +: SW];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/cpk_sample_packer.sv
module cpk_sample_packer
    import cpk_pkg::*;
#(
    parameter int NCH = 4,
    parameter int SPC = 1,
    parameter int SW  = 16
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  ch_wr_i,
    input  logic [NCH-1:0]        ch_en_i,
    input  logic [NCH*SPC*SW-1:0] ch_data_i,
    output logic                  src_ovf_o,
    output logic                  snk_wr_o,
    output logic [NCH*SPC*SW-1:0] snk_data_o,
    output logic                  snk_sync_o,
    input  logic                  snk_ovf_i
);
    localparam int N  = NCH * SPC;
    localparam int CW = $clog2(NCH + 1);
    localparam int FW = (N > 1) ? $clog2(2 * N) : 1;

    typedef struct packed {
        logic [N-1:0][SW-1:0] slots;
        logic [FW-1:0]        fill;
        logic                 head;
        logic [NCH-1:0]       en;
        cpk_emit_t            emit;
        logic [N*SW-1:0]      word;
    } st_t;

    localparam st_t ST_RST = '{slots: '0, fill: '0, head: 1'b1, en: '0, emit: '0, word: '0};

    st_t st_d, st_q;

    logic                    en_chg;
    logic [FW-1:0]           base_fill;
    logic [NCH-1:0][CW-1:0]  rank;
    logic [CW-1:0]           grp_cnt;
    logic [2*N-1:0]          ins_vld;
    logic [2*N-1:0][SW-1:0]  ins_dat;

    assign en_chg    = (ch_en_i != st_q.en);
    assign base_fill = en_chg ? '0 : st_q.fill;

    cpk_rank #(.NCH(NCH), .CW(CW)) rank_i (
        .en_i    (ch_en_i),
        .rank_o  (rank),
        .count_o (grp_cnt)
    );

    cpk_place #(.NCH(NCH), .SPC(SPC), .SW(SW), .CW(CW), .FW(FW)) place_i (
        .en_i    (ch_en_i),
        .rank_i  (rank),
        .count_i (grp_cnt),
        .fill_i  (base_fill),
        .data_i  (ch_data_i),
        .vld_o   (ins_vld),
        .dat_o   (ins_dat)
    );

    always_comb begin
        int total;
        logic [2*N-1:0][SW-1:0] merged;

        st_d      = st_q;
        st_d.emit = '0;
        st_d.en   = ch_en_i;
        if (en_chg) begin
            st_d.slots = '0;
            st_d.fill  = '0;
            st_d.head  = 1'b1;
        end

        total = int'(st_d.fill) + cpk_group_size(int'(grp_cnt), SPC);

        for (int p = 0; p < 2 * N; p++) begin
            merged[p] = '0;
            if (p < N) merged[p] = st_d.slots[p % N];
            if (ins_vld[p]) merged[p] = ins_dat[p];
        end

        if (ch_wr_i && (grp_cnt != '0)) begin
            if (total >= N) begin
                st_d.emit.wr   = 1'b1;
                st_d.emit.sync = st_d.head;
                st_d.word      = merged[N-1:0];
                for (int p = 0; p < N; p++) st_d.slots[p] = merged[p+N];
                st_d.fill = FW'(total - N);
                st_d.head = (total == N);
            end else begin
                for (int p = 0; p < N; p++) st_d.slots[p] = merged[p];
                st_d.fill = FW'(total);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= ST_RST;
        else       st_q <= st_d;
    end

    assign snk_wr_o   = st_q.emit.wr;
    assign snk_sync_o = st_q.emit.sync;
    assign snk_data_o = st_q.word;
    assign src_ovf_o  = snk_ovf_i;

endmodule

// File: rtl/cpk_sample_packer_chk.sv
module cpk_sample_packer_chk #(
    parameter int NCH = 4,
    parameter int SPC = 1,
    parameter int SW  = 16
) (
    input logic                  clk_i,
    input logic                  rst_i,
    input logic                  ch_wr_i,
    input logic [NCH-1:0]        ch_en_i,
    input logic [NCH*SPC*SW-1:0] ch_data_i,
    input logic                  src_ovf_o,
    input logic                  snk_wr_o,
    input logic [NCH*SPC*SW-1:0] snk_data_o,
    input logic                  snk_sync_o,
    input logic                  snk_ovf_i
);
    a_r1_quiet_after_reset: assert property (@(posedge clk_i)
        rst_i |=> (!snk_wr_o && !snk_sync_o));

    a_r8_no_enable_no_write: assert property (@(posedge clk_i) disable iff (rst_i)
        (ch_en_i == '0) |=> !snk_wr_o);

    a_r9_no_strobe_no_write: assert property (@(posedge clk_i) disable iff (rst_i)
        !ch_wr_i |=> !snk_wr_o);

    a_r6_sync_with_write: assert property (@(posedge clk_i) disable iff (rst_i)
        snk_sync_o |-> snk_wr_o);

    a_r6_all_enabled_synced: assert property (@(posedge clk_i) disable iff (rst_i)
        (ch_wr_i && (&ch_en_i)) |=> (snk_wr_o && snk_sync_o));

    a_r10_ovf_follow: assert property (@(posedge clk_i)
        src_ovf_o == snk_ovf_i);
endmodule

bind cpk_sample_packer cpk_sample_packer_chk #(.NCH(NCH), .SPC(SPC), .SW(SW)) chk_i (.*);

// File: tb/cpk_sample_packer_tb_top.sv
`timescale 1ns/1ps
module cpk_sample_packer_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int total = 0;
    int bad   = 0;

    // main instance: 4 channels, 1 sample, 16 bits
    logic        ch_wr = 1'b0;
    logic [3:0]  ch_en = '0;
    logic [63:0] ch_data = '0;
    logic        src_ovf, snk_wr, snk_sync;
    logic [63:0] snk_data;
    logic        snk_ovf = 1'b0;

    cpk_sample_packer dut_i (
        .clk_i(clk), .rst_i(rst), .ch_wr_i(ch_wr), .ch_en_i(ch_en), .ch_data_i(ch_data),
        .src_ovf_o(src_ovf), .snk_wr_o(snk_wr), .snk_data_o(snk_data),
        .snk_sync_o(snk_sync), .snk_ovf_i(snk_ovf));

    // second instance: 4 channels, 2 samples, 8 bits
    logic        w2 = 1'b0;
    logic [3:0]  e2 = '0;
    logic [63:0] d2 = '0;
    logic        o2, wr2, sy2;
    logic [63:0] q2;

    cpk_sample_packer #(.NCH(4), .SPC(2), .SW(8)) dut2_i (
        .clk_i(clk), .rst_i(rst), .ch_wr_i(w2), .ch_en_i(e2), .ch_data_i(d2),
        .src_ovf_o(o2), .snk_wr_o(wr2), .snk_data_o(q2),
        .snk_sync_o(sy2), .snk_ovf_i(1'b0));

    function automatic logic [15:0] v(int c, int t);
        return 16'((c + 1) * 16'h1000 + t);
    endfunction

    function automatic logic [63:0] chv(int t);
        return {v(3, t), v(2, t), v(1, t), v(0, t)};
    endfunction

    function automatic logic [63:0] w4(logic [15:0] s0, logic [15:0] s1,
                                       logic [15:0] s2, logic [15:0] s3);
        return {s3, s2, s1, s0};
    endfunction

    function automatic logic [7:0] b(int c, int s, int t);
        return 8'((c << 4) | (s << 3) | t);
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle, return at the following falling edge
    task automatic step(logic [3:0] en, logic wr, int t);
        ch_en   = en;
        ch_wr   = wr;
        ch_data = chv(t);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 wr", 64'(snk_wr), 64'd0);
        chk("R1 sync", 64'(snk_sync), 64'd0);
    endtask

    task automatic t_all_enabled();
        step(4'b1111, 1'b1, 1);
        chk("R4 wr", 64'(snk_wr), 64'd1);
        chk("R2 data", snk_data, chv(1));
        chk("R6 sync", 64'(snk_sync), 64'd1);
        step(4'b1111, 1'b1, 2);
        chk("R2 data2", snk_data, chv(2));
        step(4'b1111, 1'b0, 3);
        chk("R4 one-cycle pulse", 64'(snk_wr), 64'd0);
    endtask

    task automatic t_subset_carry();
        step(4'b1011, 1'b1, 1);
        chk("R4 not full", 64'(snk_wr), 64'd0);
        step(4'b1011, 1'b1, 2);
        chk("R4 wr w1", 64'(snk_wr), 64'd1);
        chk("R2 w1", snk_data, w4(v(0,1), v(1,1), v(3,1), v(0,2)));
        chk("R6 w1 sync", 64'(snk_sync), 64'd1);
        step(4'b1011, 1'b1, 3);
        chk("R5 w2", snk_data, w4(v(1,2), v(3,2), v(0,3), v(1,3)));
        chk("R6 w2 sync", 64'(snk_sync), 64'd0);
        step(4'b1011, 1'b1, 4);
        chk("R5 w3", snk_data, w4(v(3,3), v(0,4), v(1,4), v(3,4)));
        chk("R6 w3 sync", 64'(snk_sync), 64'd0);
        step(4'b1011, 1'b1, 5);
        chk("R5 partial", 64'(snk_wr), 64'd0);
    endtask

    task automatic t_enable_change();
        step(4'b0101, 1'b0, 0);
        chk("R7 no flush", 64'(snk_wr), 64'd0);
        step(4'b0101, 1'b1, 5);
        chk("R7 half", 64'(snk_wr), 64'd0);
        step(4'b0101, 1'b1, 6);
        chk("R7 wr", 64'(snk_wr), 64'd1);
        chk("R7 data", snk_data, w4(v(0,5), v(2,5), v(0,6), v(2,6)));
        chk("R7 sync", 64'(snk_sync), 64'd1);
        // strobe in the change cycle goes into the emptied buffer
        step(4'b0101, 1'b1, 7);
        step(4'b0011, 1'b1, 8);
        chk("R7 change+strobe", 64'(snk_wr), 64'd0);
        step(4'b0011, 1'b1, 9);
        chk("R7 change+strobe data", snk_data, w4(v(0,8), v(1,8), v(0,9), v(1,9)));
    endtask

    task automatic t_idle();
        for (int i = 0; i < 3; i++) begin
            step(4'b0000, 1'b1, 10 + i);
            chk("R8 ignored", 64'(snk_wr), 64'd0);
        end
        for (int i = 0; i < 2; i++) begin
            step(4'b1111, 1'b0, 20);
            chk("R9 no strobe", 64'(snk_wr), 64'd0);
        end
        step(4'b1111, 1'b1, 21);
        chk("R8 nothing kept", snk_data, chv(21));
        chk("R8 sync", 64'(snk_sync), 64'd1);
        step(4'b1111, 1'b0, 0);
    endtask

    task automatic t_overflow();
        snk_ovf = 1'b1;
        #1;
        chk("R10 high", 64'(src_ovf), 64'd1);
        snk_ovf = 1'b0;
        #1;
        chk("R10 low", 64'(src_ovf), 64'd0);
        @(negedge clk);
    endtask

    task automatic t_multi_sample();
        e2 = 4'b0110;
        w2 = 1'b1;
        for (int t = 1; t <= 2; t++) begin
            for (int c = 0; c < 4; c++)
                for (int s = 0; s < 2; s++)
                    d2[(c*2+s)*8 +: 8] = b(c, s, t);
            @(negedge clk);
            if (t == 1) chk("R3 not full", 64'(wr2), 64'd0);
        end
        w2 = 1'b0;
        chk("R3 wr", 64'(wr2), 64'd1);
        chk("R3 order", q2, {b(2,1,2), b(1,1,2), b(2,0,2), b(1,0,2),
                             b(2,1,1), b(1,1,1), b(2,0,1), b(1,0,1)});
        chk("R3 sync", 64'(sy2), 64'd1);
        @(negedge clk);
    endtask

    initial begin
        #50000;
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_all_enabled();
        t_subset_carry();
        t_enable_change();
        t_idle();
        t_overflow();
        t_multi_sample();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule